// File: doc/BRIEF.md
# Background Timing Skew Estimator for a Four-Way Interleaved Converter

This block watches the output of a four-way time-interleaved analog-to-digital converter and keeps a running estimate of how far lanes 2, 3 and 4 sample early or late compared with lane 1. Lane 1 is the reference, and its skew is zero by definition. The estimator runs in the background on live data and needs no test signal. For each lane it forms absolute differences between neighbouring samples and subtracts one of them from the other. The result is scaled by a power-of-two step size and added into a signed saturating accumulator. The datapath uses no multiplier.

A frame is four lane words presented together, marked by a strobe. Some updates need the lane 1 sample of the following frame. The block therefore keeps the last frame and runs the update for it when the next strobed frame arrives. A valid pulse follows each update. Each estimate leaves the block as a signed Q1.15 fraction of the aggregate sample period. A downstream fractional-delay corrector consumes these estimates and closes the loop.

Top module: `skew_lms_est`

## Requirements
- R1: While the active-low reset is asserted, and in the first cycle after release, all three estimates read 0 and the valid output reads 0.
- R2: The first strobed frame after reset only fills the hold register. It produces no update: the valid output stays 0 and the estimates stay 0.
- R3: The frame word holds lane 1 in bits [7:0], lane 2 in [15:8], lane 3 in [23:16] and lane 4 in [31:24], each as an unsigned code. For the held frame (a1..a4), the lane 2 error is |a3-a2| - |a2-a1|.
- R4: The lane 3 error is |n1-a3| - |a3-a1|, where n1 is the lane 1 code of the newly strobed frame.
- R5: The lane 4 error is |n1-a4| - |a4-a3|.
- R6: An accumulator of ACC_W bits (default 28) represents alpha with ACC_W-1 fraction bits. Each update adds the error times 2^-MU_SHIFT (default 19), which is the error shifted left by ACC_W-1-MU_SHIFT. The exported estimate is the top 16 accumulator bits.
- R7: An accumulator saturates at its most positive and most negative values and never wraps.
- R8: A cycle with the strobe low changes no estimate. The held frame stays in place across such gaps.
- R9: The valid output is high for exactly one cycle after each clock edge at which an update took place. The estimates change only at those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | Strobe marking a complete four-lane frame |
| frame_data | input | 32 | Four packed 8-bit lane codes, lane 1 in the low byte |
| est_vld | output | 1 | One-cycle pulse after each estimate update |
| alpha_c2 | output | 16 | Lane 2 skew estimate, signed Q1.15 |
| alpha_c3 | output | 16 | Lane 3 skew estimate, signed Q1.15 |
| alpha_c4 | output | 16 | Lane 4 skew estimate, signed Q1.15 |

## Verification
The bound checker watches four things on every cycle. The estimates move only together with a valid pulse. A pulse always follows a strobe. No single update moves an estimate further than the largest possible error allows. An estimate near one rail never jumps to the other. Other behaviour can only be shown by running scenarios with known data: the exact error formula for each lane, the use of the next frame's lane 1 code, the skipped first frame, and where saturation settles. The bench therefore drives random, ramp and constant frame streams with gaps, plus a long run of extreme frames, and compares all three estimates against an arithmetic model after every clock.

// File: rtl/skew_pkg.sv
package skew_pkg;

  localparam int unsigned NUM_LANE = 4;
  localparam int unsigned NUM_EST  = NUM_LANE - 1;
  // tap 4 is lane 1 of the following frame
  localparam int unsigned NUM_TAP  = NUM_LANE + 1;

  // taps (a, b, c) per estimated lane: error = |c-b| - |b-a|
  function automatic int unsigned tap_a(int unsigned k);
    case (k)
      0:       return 0;
      1:       return 0;
      default: return 2;
    endcase
  endfunction

  function automatic int unsigned tap_b(int unsigned k);
    case (k)
      0:       return 1;
      1:       return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int unsigned tap_c(int unsigned k);
    case (k)
      0:       return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/skew_frame_hold.sv
module skew_frame_hold
  import skew_pkg::*;
#(
  parameter int unsigned SMP_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frame_vld,
  input  logic [NUM_LANE*SMP_W-1:0]           frame_data,
  output logic [NUM_LANE-1:0][SMP_W-1:0]      held,
  output logic                                held_ok
);

  logic [NUM_LANE-1:0][SMP_W-1:0] held_nxt;
  logic                           ok_nxt;

  always_comb begin
    held_nxt = held;
    ok_nxt   = held_ok;
    if (frame_vld) begin
      for (int i = 0; i < int'(NUM_LANE); i++) begin
        held_nxt[i] = frame_data[i*SMP_W +: SMP_W];
      end
      ok_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= '0;
      held_ok <= 1'b0;
    end else begin
      held    <= held_nxt;
      held_ok <= ok_nxt;
    end
  end

endmodule

// File: rtl/skew_err_terms.sv
module skew_err_terms
  import skew_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  localparam int unsigned ERR_W = SMP_W + 1
) (
  input  logic [NUM_LANE-1:0][SMP_W-1:0]        held,
  input  logic [SMP_W-1:0]                      next_c1,
  output logic signed [NUM_EST-1:0][ERR_W-1:0]  err
);

  logic [NUM_TAP-1:0][SMP_W-1:0] tap;

  always_comb begin
    for (int i = 0; i < int'(NUM_LANE); i++) tap[i] = held[i];
    tap[NUM_LANE] = next_c1;
  end

  for (genvar k = 0; k < int'(NUM_EST); k++) begin : g_lane
    localparam int unsigned IA = tap_a(k);
    localparam int unsigned IB = tap_b(k);
    localparam int unsigned IC = tap_c(k);

    logic [SMP_W-1:0] d_cb;
    logic [SMP_W-1:0] d_ba;

    always_comb begin
      d_cb = (tap[IC] > tap[IB]) ? (tap[IC] - tap[IB]) : (tap[IB] - tap[IC]);
      d_ba = (tap[IB] > tap[IA]) ? (tap[IB] - tap[IA]) : (tap[IA] - tap[IB]);
      err[k] = $signed({1'b0, d_cb}) - $signed({1'b0, d_ba});
    end
  end

endmodule

// File: rtl/skew_lms_acc.sv
module skew_lms_acc #(
  parameter int unsigned ERR_W    = 9,
  parameter int unsigned ACC_W    = 28,
  parameter int unsigned MU_SHIFT = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic signed [ERR_W-1:0] err,
  output logic signed [ACC_W-1:0] acc
);

  localparam int INC_SH = int'(ACC_W) - 1 - int'(MU_SHIFT);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] err_ext;
  logic signed [ACC_W-1:0] inc;
  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] sat;
  logic signed [ACC_W-1:0] acc_nxt;

  assign err_ext = {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};

  if (INC_SH >= 0) begin : g_shl
    assign inc = err_ext <<< INC_SH;
  end else begin : g_shr
    assign inc = err_ext >>> (-INC_SH);
  end

  always_comb begin
    sum = {acc[ACC_W-1], acc} + {inc[ACC_W-1], inc};
    if (sum[ACC_W] != sum[ACC_W-1]) begin
      sat = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    end else begin
      sat = sum[ACC_W-1:0];
    end
    acc_nxt = upd_en ? sat : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end

endmodule

// File: rtl/skew_lms_est.sv
module skew_lms_est
  import skew_pkg::*;
#(
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned ACC_W    = 28,
  parameter int unsigned MU_SHIFT = 19,
  parameter int unsigned OUT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_vld,
  input  logic [NUM_LANE*SMP_W-1:0]     frame_data,
  output logic                          est_vld,
  output logic signed [OUT_W-1:0]       alpha_c2,
  output logic signed [OUT_W-1:0]       alpha_c3,
  output logic signed [OUT_W-1:0]       alpha_c4
);

  localparam int unsigned ERR_W = SMP_W + 1;

  logic [NUM_LANE-1:0][SMP_W-1:0]       held;
  logic                                 held_ok;
  logic signed [NUM_EST-1:0][ERR_W-1:0] err;
  logic signed [NUM_EST-1:0][ACC_W-1:0] acc;
  logic                                 do_upd;
  logic                                 vld_nxt;

  skew_frame_hold #(.SMP_W(SMP_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_vld  (frame_vld),
    .frame_data (frame_data),
    .held       (held),
    .held_ok    (held_ok)
  );

  skew_err_terms #(.SMP_W(SMP_W)) u_err (
    .held    (held),
    .next_c1 (frame_data[SMP_W-1:0]),
    .err     (err)
  );

  assign do_upd = frame_vld & held_ok;

  for (genvar k = 0; k < int'(NUM_EST); k++) begin : g_acc
    skew_lms_acc #(
      .ERR_W    (ERR_W),
      .ACC_W    (ACC_W),
      .MU_SHIFT (MU_SHIFT)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (do_upd),
      .err    (err[k]),
      .acc    (acc[k])
    );
  end

  assign vld_nxt = do_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est_vld <= 1'b0;
    else        est_vld <= vld_nxt;
  end

  assign alpha_c2 = acc[0][ACC_W-1 -: OUT_W];
  assign alpha_c3 = acc[1][ACC_W-1 -: OUT_W];
  assign alpha_c4 = acc[2][ACC_W-1 -: OUT_W];

endmodule

// File: rtl/skew_lms_est_chk.sv
module skew_lms_est_chk #(
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned ACC_W    = 28,
  parameter int unsigned MU_SHIFT = 19,
  parameter int unsigned OUT_W    = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_vld,
  input logic                    est_vld,
  input logic signed [OUT_W-1:0] alpha_c2,
  input logic signed [OUT_W-1:0] alpha_c3,
  input logic signed [OUT_W-1:0] alpha_c4
);

  localparam longint ERR_MAX = (longint'(1) <<< SMP_W) - 1;
  localparam longint INC_MAX = (ACC_W - 1 >= MU_SHIFT) ?
                               (ERR_MAX <<< (ACC_W - 1 - MU_SHIFT)) : ERR_MAX;
  localparam longint STEP    = (INC_MAX >>> (ACC_W - OUT_W)) + 2;
  localparam longint HALF    = longint'(1) <<< (OUT_W - 2);

  function automatic longint mag(logic signed [OUT_W-1:0] a, logic signed [OUT_W-1:0] b);
    longint d;
    d = longint'(a) - longint'(b);
    return (d < 0) ? -d : d;
  endfunction

  function automatic logic wrapped(logic signed [OUT_W-1:0] prev, logic signed [OUT_W-1:0] now);
    return ((longint'(prev) > HALF) && (now < 0)) ||
           ((longint'(prev) < -HALF) && (now >= 0));
  endfunction

  AST_VLD_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    est_vld |-> $past(frame_vld)); // R9

  AST_MOVE_ONLY_ON_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(alpha_c2) && $stable(alpha_c3) && $stable(alpha_c4)) |-> est_vld); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_vld) |-> ($stable(alpha_c2) && $stable(alpha_c3) && $stable(alpha_c4))); // R8

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mag(alpha_c2, $past(alpha_c2)) <= STEP) && (mag(alpha_c3, $past(alpha_c3)) <= STEP) &&
    (mag(alpha_c4, $past(alpha_c4)) <= STEP)); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrapped($past(alpha_c2), alpha_c2) && !wrapped($past(alpha_c3), alpha_c3) &&
    !wrapped($past(alpha_c4), alpha_c4)); // R7

endmodule

bind skew_lms_est skew_lms_est_chk #(
  .SMP_W    (SMP_W),
  .ACC_W    (ACC_W),
  .MU_SHIFT (MU_SHIFT),
  .OUT_W    (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_vld (frame_vld),
  .est_vld   (est_vld),
  .alpha_c2  (alpha_c2),
  .alpha_c3  (alpha_c3),
  .alpha_c4  (alpha_c4)
);

// File: tb/tb_skew_lms_est.sv
`timescale 1ns/1ps
module tb_skew_lms_est;

  localparam int ACC_W = 28;
  localparam int MU_SH = 19;
  localparam longint A_MAX = (longint'(1) <<< (ACC_W - 1)) - 1;
  localparam longint A_MIN = -(longint'(1) <<< (ACC_W - 1));

  logic        clk;
  logic        rst_n;
  logic        frame_vld;
  logic [31:0] frame_data;
  logic        est_vld;
  logic signed [15:0] alpha_c2, alpha_c3, alpha_c4;

  int n_chk;
  int n_fail;
  bit done;

  longint m_acc [3];
  int     m_prev [4];
  bit     m_have;
  bit     m_vld;
  int unsigned lcg;

  skew_lms_est dut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_data(frame_data),
    .est_vld(est_vld), .alpha_c2(alpha_c2), .alpha_c3(alpha_c3), .alpha_c4(alpha_c4)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic longint top16(longint a);
    return a >>> (ACC_W - 16);
  endfunction

  task automatic check_all(string t2, string t3, string t4, string tv);
    chk(t2, alpha_c2, top16(m_acc[0]));
    chk(t3, alpha_c3, top16(m_acc[1]));
    chk(t4, alpha_c4, top16(m_acc[2]));
    chk(tv, est_vld, m_vld);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; frame_vld = 1'b0; frame_data = '0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) m_acc[i] = 0;
    m_have = 1'b0; m_vld = 1'b0;
    check_all("R1", "R1", "R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", "R1", "R1", "R1");
  endtask

  // one cycle: drive at negedge, model the edge, sample at next negedge
  task automatic step(bit v, logic [31:0] d, string tg);
    int x [5];
    int e [3];
    frame_vld = v; frame_data = d;
    m_vld = 1'b0;
    if (v) begin
      if (m_have) begin
        for (int i = 0; i < 4; i++) x[i] = m_prev[i];
        x[4] = int'(d[7:0]);
        e[0] = absd(x[2], x[1]) - absd(x[1], x[0]);
        e[1] = absd(x[4], x[2]) - absd(x[2], x[0]);
        e[2] = absd(x[4], x[3]) - absd(x[3], x[2]);
        for (int k = 0; k < 3; k++) begin
          m_acc[k] = m_acc[k] + (longint'(e[k]) <<< (ACC_W - 1 - MU_SH));
          if (m_acc[k] > A_MAX) m_acc[k] = A_MAX;
          if (m_acc[k] < A_MIN) m_acc[k] = A_MIN;
        end
        m_vld = 1'b1;
      end
      for (int i = 0; i < 4; i++) m_prev[i] = int'(d[8*i +: 8]);
      m_have = 1'b1;
    end
    @(negedge clk);
    if (tg != "") check_all(tg, tg, tg, tg);
    else if (v) check_all("R3", "R4", "R5", "R9");
    else check_all("R8", "R8", "R8", "R8");
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_chk = 0; n_fail = 0; done = 1'b0; lcg = 32'h1234_5678;
    rst_n = 1'b0; frame_vld = 1'b0; frame_data = '0;
    do_reset();

    // R2: first frame only loads; R6: single step scaling 255 << 8 -> 15
    step(1'b1, 32'h00FF_0000, "R2");
    chk("R2", alpha_c2, 0);
    step(1'b1, 32'h00FF_0000, "R6");
    chk("R6", alpha_c2, 15);
    chk("R6", alpha_c4, -16);
    chk("R6", alpha_c3, 0);

    // R8: gap keeps held frame; next lane-1 code pairs with it
    step(1'b0, 32'hFFFF_FFFF, "R8");
    step(1'b0, 32'h1111_1111, "R8");
    step(1'b1, 32'h0000_0080, "");

    // random frames with gaps
    for (int n = 0; n < 1500; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step((n % 5) != 4, lcg, "");
    end
    // ramp frames
    for (int n = 0; n < 400; n++) begin
      step(1'b1, {8'(4*n+3), 8'(4*n+2), 8'(4*n+1), 8'(4*n)}, "");
    end
    // constant frames: zero error, estimates hold
    for (int n = 0; n < 20; n++) step(1'b1, 32'h5A5A_5A5A, "");

    // R1 mid-run reset, then R7 saturation
    do_reset();
    for (int n = 0; n < 2100; n++) step(1'b1, 32'h00FF_0000, "");
    chk("R7", alpha_c2, 32767);
    chk("R7", alpha_c4, -32768);
    chk("R7", alpha_c3, 0);
    step(1'b1, 32'h00FF_0000, "R7");
    chk("R7", alpha_c2, 32767);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule